// File: doc/BRIEF.md
# Instruction Sequencer with Per-Unit Activity Enables

This block is the control unit of a small 8-bit controller. It reads each 16-bit instruction from a 256-byte instruction store as two bytes, high byte first. The high byte carries the instruction class in its low nibble and a function field in its high nibble. The low byte is a direct 8-bit operand address. After decoding, the block raises the strobes the instruction needs for the register file, ALU, data RAM, shifter and the two I/O ports. Port 0 is output-only and port 1 is input-only.

Besides the strobes, every decoded instruction produces a set of per-unit activity enables, one bit per functional unit. These enables come straight from flops and are high only in the execute cycle, and only for the units that the instruction uses. Idle units therefore see no clock activity. Each instruction takes four cycles: fetch-high, fetch-low, decode, execute. A two-state reset sequence runs first and then loads the program counter with a boot address.

Top module: `instr_sequencer`

## Requirements
- R1: While `rst` is high, all unit enables and all strobes are low and `rom_addr` is 0. After `rst` falls, two reset-sequence cycles pass, and then the first fetch presents `BOOT_ADDR` (default 0x10) on `rom_addr`.
- R2: Each instruction takes four cycles: high-byte fetch with `rom_addr` = PC, low-byte fetch with `rom_addr` = PC+1 (modulo 256), decode, then execute. After that comes the next high-byte fetch.
- R3: Every instruction that is not a taken branch advances the PC by 2, modulo 256.
- R4: Class 5 (jump) always loads the PC with the operand byte. Class 6 (jump-if-zero) does so only when `zero_flag` is high in its decode cycle, and otherwise advances by 2.
- R5: `unit_en` bit 0 is the register file, bit 1 the ALU, bit 2 the data RAM, bit 3 the shifter and bit 4 the I/O ports. In the execute cycle it equals exactly the set the class uses: load 0x05, store 0x05, ALU 0x07, shift 0x09, output 0x11, input 0x11, all other classes 0. In every other cycle it is 0.
- R6: The strobes are high only in the execute cycle. Class 1 (load) raises ram_rd and rf_wr. Class 2 (store) raises rf_rd and ram_wr. Class 3 (ALU) raises alu_go, ram_rd and rf_wr. Class 4 (shift) raises shf_go and rf_wr. Class 7 (output) raises rf_rd and out_wr. Class 8 (input) raises in_rd and rf_wr.
- R7: In the execute cycle, `mem_addr` equals {opcode[5:4], operand}, which selects one of four 256-byte pages of the 1K data RAM, and `fn_code` equals opcode[7:4].
- R8: Classes 0 and 9 to 15 are no-ops. They raise no enable and no strobe, and they advance the PC by 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rom_addr | output | 8 | Instruction store byte address |
| rom_data | input | 8 | Instruction store byte read at `rom_addr` in the same cycle |
| zero_flag | input | 1 | ALU zero status, sampled in the decode cycle |
| unit_en | output | 5 | Per-unit activity enables |
| rf_wr | output | 1 | Register file write strobe |
| rf_rd | output | 1 | Register file read strobe |
| alu_go | output | 1 | ALU operate strobe |
| shf_go | output | 1 | Shifter operate strobe |
| ram_wr | output | 1 | Data RAM write strobe |
| ram_rd | output | 1 | Data RAM read strobe |
| out_wr | output | 1 | Output port write strobe |
| in_rd | output | 1 | Input port read strobe |
| mem_addr | output | 10 | Paged direct data address |
| fn_code | output | 4 | Function field for the addressed unit |

## Verification
A state machine that is out of step shows up within one instruction. It appears either as `rom_addr` not being PC+1 in the second cycle, or as enables appearing outside the fourth cycle. A wrong PC update appears at the very next high-byte fetch address. A wrong decode appears in the same execute cycle as an enable set or strobe set that does not match the class. The instruction store is filled at random from a fixed seed, so branches send execution all over the address space. Directed bytes add the 0xFE-to-0x00 wrap, both outcomes of jump-if-zero, and a reset in the middle of the run.

// File: rtl/seq_pkg.sv
package seq_pkg;

    localparam int BYTE_W    = 8;
    localparam int NUM_UNITS = 5;

    localparam int U_RF   = 0;
    localparam int U_ALU  = 1;
    localparam int U_RAM  = 2;
    localparam int U_SHF  = 3;
    localparam int U_PORT = 4;

    localparam logic [3:0] CL_LOAD  = 4'd1;
    localparam logic [3:0] CL_STORE = 4'd2;
    localparam logic [3:0] CL_ALU   = 4'd3;
    localparam logic [3:0] CL_SHIFT = 4'd4;
    localparam logic [3:0] CL_JUMP  = 4'd5;
    localparam logic [3:0] CL_JZ    = 4'd6;
    localparam logic [3:0] CL_OUT   = 4'd7;
    localparam logic [3:0] CL_IN    = 4'd8;

    typedef enum logic [2:0] {
        ST_RST1, ST_RST2, ST_FHI, ST_FLO, ST_DEC, ST_EXE
    } seq_state_t;

    typedef struct packed {
        logic [NUM_UNITS-1:0] en;
        logic rf_wr;
        logic rf_rd;
        logic alu_go;
        logic shf_go;
        logic ram_wr;
        logic ram_rd;
        logic out_wr;
        logic in_rd;
    } ctl_t;

    // Strobes per class; enables follow from which strobes a unit gets.
    function automatic ctl_t decode_class(input logic [3:0] cls);
        ctl_t c;
        c = '0;
        case (cls)
            CL_LOAD:  begin c.ram_rd = 1'b1; c.rf_wr = 1'b1; end
            CL_STORE: begin c.rf_rd  = 1'b1; c.ram_wr = 1'b1; end
            CL_ALU:   begin c.alu_go = 1'b1; c.ram_rd = 1'b1; c.rf_wr = 1'b1; end
            CL_SHIFT: begin c.shf_go = 1'b1; c.rf_wr = 1'b1; end
            CL_OUT:   begin c.rf_rd  = 1'b1; c.out_wr = 1'b1; end
            CL_IN:    begin c.in_rd  = 1'b1; c.rf_wr = 1'b1; end
            default:  c = '0;
        endcase
        c.en[U_RF]   = c.rf_wr | c.rf_rd;
        c.en[U_ALU]  = c.alu_go;
        c.en[U_RAM]  = c.ram_wr | c.ram_rd;
        c.en[U_SHF]  = c.shf_go;
        c.en[U_PORT] = c.out_wr | c.in_rd;
        return c;
    endfunction

    function automatic logic branch_taken(input logic [3:0] cls, input logic zf);
        return (cls == CL_JUMP) || ((cls == CL_JZ) && zf);
    endfunction

endpackage

// File: rtl/seq_fsm.sv
module seq_fsm
    import seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    output seq_state_t state
);

    seq_state_t state_d;

    always_comb begin
        case (state)
            ST_RST1: state_d = ST_RST2;
            ST_RST2: state_d = ST_FHI;
            ST_FHI:  state_d = ST_FLO;
            ST_FLO:  state_d = ST_DEC;
            ST_DEC:  state_d = ST_EXE;
            ST_EXE:  state_d = ST_FHI;
            default: state_d = ST_RST1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_RST1;
        else     state <= state_d;
    end

    // R2
    exe_to_fetch_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_EXE) |=> (state == ST_FHI));

    // R2
    fhi_to_flo_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FHI) |=> (state == ST_FLO));

endmodule

// File: rtl/seq_fetch.sv
module seq_fetch
    import seq_pkg::*;
#(
    parameter logic [BYTE_W-1:0] BOOT_ADDR = 8'h10
) (
    input  logic              clk,
    input  logic              rst,
    input  seq_state_t        state,
    input  logic [BYTE_W-1:0] rom_data,
    input  logic              zero_flag,
    output logic [BYTE_W-1:0] rom_addr,
    output logic [BYTE_W-1:0] opcode,
    output logic [BYTE_W-1:0] operand
);

    logic [BYTE_W-1:0] pc_q;
    logic              taken;

    assign taken    = branch_taken(opcode[3:0], zero_flag);
    assign rom_addr = (state == ST_FLO) ? pc_q + BYTE_W'(1) : pc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q    <= '0;
            opcode  <= '0;
            operand <= '0;
        end else begin
            case (state)
                ST_RST1: pc_q    <= '0;
                ST_RST2: pc_q    <= BOOT_ADDR;
                ST_FHI:  opcode  <= rom_data;
                ST_FLO:  operand <= rom_data;
                ST_DEC:  pc_q    <= taken ? operand : pc_q + BYTE_W'(2);
                default: ;
            endcase
        end
    end

    // R3
    pc_step_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DEC && !taken) |=> (pc_q == $past(pc_q) + BYTE_W'(2)));

    // R4
    pc_branch_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DEC && taken) |=> (pc_q == $past(operand)));

endmodule

// File: rtl/seq_decode.sv
module seq_decode
    import seq_pkg::*;
#(
    parameter int PAGE_W = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  seq_state_t               state,
    input  logic [BYTE_W-1:0]        opcode,
    input  logic [BYTE_W-1:0]        operand,
    output ctl_t                     ctl_q,
    output logic [PAGE_W+BYTE_W-1:0] mem_addr,
    output logic [3:0]               fn_code
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q    <= '0;
            mem_addr <= '0;
            fn_code  <= '0;
        end else if (state == ST_DEC) begin
            ctl_q    <= decode_class(opcode[3:0]);
            mem_addr <= {opcode[4 +: PAGE_W], operand};
            fn_code  <= opcode[7:4];
        end else begin
            ctl_q    <= '0;
        end
    end

    // R5
    en_only_exec_chk: assert property (@(posedge clk) disable iff (rst)
        (|ctl_q.en) |-> (state == ST_EXE));

    // R6
    ram_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(ctl_q.ram_wr && ctl_q.ram_rd));

    // R5
    en_count_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(ctl_q.en) <= 3);

    // R6
    strobe_exec_chk: assert property (@(posedge clk) disable iff (rst)
        (state != ST_EXE) |-> (ctl_q == '0));

endmodule

// File: rtl/instr_sequencer.sv
module instr_sequencer
    import seq_pkg::*;
#(
    parameter logic [7:0] BOOT_ADDR = 8'h10,
    parameter int         PAGE_W    = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    output logic [7:0]               rom_addr,
    input  logic [7:0]               rom_data,
    input  logic                     zero_flag,
    output logic [NUM_UNITS-1:0]     unit_en,
    output logic                     rf_wr,
    output logic                     rf_rd,
    output logic                     alu_go,
    output logic                     shf_go,
    output logic                     ram_wr,
    output logic                     ram_rd,
    output logic                     out_wr,
    output logic                     in_rd,
    output logic [PAGE_W+7:0]        mem_addr,
    output logic [3:0]               fn_code
);

    seq_state_t  state;
    logic [7:0]  opcode;
    logic [7:0]  operand;
    ctl_t        ctl_q;

    seq_fsm u_fsm (
        .clk   (clk),
        .rst   (rst),
        .state (state)
    );

    seq_fetch #(.BOOT_ADDR(BOOT_ADDR)) u_fetch (
        .clk       (clk),
        .rst       (rst),
        .state     (state),
        .rom_data  (rom_data),
        .zero_flag (zero_flag),
        .rom_addr  (rom_addr),
        .opcode    (opcode),
        .operand   (operand)
    );

    seq_decode #(.PAGE_W(PAGE_W)) u_dec (
        .clk      (clk),
        .rst      (rst),
        .state    (state),
        .opcode   (opcode),
        .operand  (operand),
        .ctl_q    (ctl_q),
        .mem_addr (mem_addr),
        .fn_code  (fn_code)
    );

    assign unit_en = ctl_q.en;
    assign rf_wr   = ctl_q.rf_wr;
    assign rf_rd   = ctl_q.rf_rd;
    assign alu_go  = ctl_q.alu_go;
    assign shf_go  = ctl_q.shf_go;
    assign ram_wr  = ctl_q.ram_wr;
    assign ram_rd  = ctl_q.ram_rd;
    assign out_wr  = ctl_q.out_wr;
    assign in_rd   = ctl_q.in_rd;

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        $past(rst) |-> (unit_en == '0));

endmodule

// File: tb/tb_instr_sequencer.sv
module tb_instr_sequencer;

    localparam logic [7:0] BOOT = 8'h10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  rom_addr;
    logic [7:0]  rom_data;
    logic        zero_flag = 1'b0;
    logic [4:0]  unit_en;
    logic        rf_wr, rf_rd, alu_go, shf_go, ram_wr, ram_rd, out_wr, in_rd;
    logic [9:0]  mem_addr;
    logic [3:0]  fn_code;

    logic [7:0]  rom [256];
    int          total = 0;
    int          bad   = 0;
    bit          finished = 0;

    always #4 clk = ~clk;

    assign rom_data = rom[rom_addr];

    instr_sequencer #(.BOOT_ADDR(BOOT), .PAGE_W(2)) dut (
        .clk(clk), .rst(rst), .rom_addr(rom_addr), .rom_data(rom_data),
        .zero_flag(zero_flag), .unit_en(unit_en), .rf_wr(rf_wr), .rf_rd(rf_rd),
        .alu_go(alu_go), .shf_go(shf_go), .ram_wr(ram_wr), .ram_rd(ram_rd),
        .out_wr(out_wr), .in_rd(in_rd), .mem_addr(mem_addr), .fn_code(fn_code)
    );

    function automatic logic [7:0] strobes();
        return {rf_wr, rf_rd, alu_go, shf_go, ram_wr, ram_rd, out_wr, in_rd};
    endfunction

    // Expected enables per class (R5, R8)
    function automatic logic [4:0] exp_en(input logic [3:0] c);
        case (c)
            4'd1, 4'd2: return 5'h05;
            4'd3:       return 5'h07;
            4'd4:       return 5'h09;
            4'd7, 4'd8: return 5'h11;
            default:    return 5'h00;
        endcase
    endfunction

    // Expected strobes {rf_wr,rf_rd,alu,shf,ram_wr,ram_rd,out_wr,in_rd} (R6, R8)
    function automatic logic [7:0] exp_stb(input logic [3:0] c);
        case (c)
            4'd1:    return 8'b1000_0100;
            4'd2:    return 8'b0100_1000;
            4'd3:    return 8'b1010_0100;
            4'd4:    return 8'b1001_0000;
            4'd7:    return 8'b0100_0010;
            4'd8:    return 8'b1000_0001;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] exp_next_pc(input logic [7:0] pc, input logic [3:0] c,
                                               input logic [7:0] opnd, input logic zf);
        if (c == 4'd5 || (c == 4'd6 && zf)) return opnd;
        return pc + 8'd2;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Runs one instruction starting at a negedge in the high-byte fetch cycle.
    task automatic run_instr(inout logic [7:0] pc_e, input string pc_req);
        logic [7:0] hi, lo;
        logic [3:0] cls;
        logic       zf;
        chk(rom_addr == pc_e, pc_req, rom_addr, pc_e);
        if (pc_e == 8'h00)      zf = 1'b1;
        else if (pc_e == 8'h40) zf = 1'b0;
        else                    zf = 1'($urandom_range(0, 1));
        zero_flag = zf;
        hi  = rom[pc_e];
        lo  = rom[8'(pc_e + 8'd1)];
        cls = hi[3:0];
        @(negedge clk);
        chk(rom_addr == 8'(pc_e + 8'd1), "R2 low-byte address", rom_addr, 8'(pc_e + 8'd1));
        @(negedge clk);
        chk(unit_en == 5'h0 && strobes() == 8'h0, "R5 decode cycle quiet",
            {unit_en, strobes()}, 0);
        @(negedge clk);
        chk(unit_en == exp_en(cls), (cls == 0 || cls > 8) ? "R8 no-op enables" : "R5 enables",
            unit_en, exp_en(cls));
        chk(strobes() == exp_stb(cls), "R6 strobes", strobes(), exp_stb(cls));
        chk(mem_addr == {hi[5:4], lo} && fn_code == hi[7:4], "R7 address and function",
            {fn_code, mem_addr}, {hi[7:4], hi[5:4], lo});
        pc_e = exp_next_pc(pc_e, cls, lo, zf);
        @(negedge clk);
    endtask

    task automatic run_prog(input int n);
        logic [7:0] pc_e;
        string      req;
        pc_e = BOOT;
        req  = "R1 first fetch at boot";
        for (int i = 0; i < n; i++) begin
            logic [3:0] c;
            c = rom[pc_e][3:0];
            run_instr(pc_e, req);
            if (c == 4'd5 || c == 4'd6) req = "R4 branch target";
            else if (c == 0 || c > 8)   req = "R8 no-op advance";
            else                        req = "R3 advance by 2";
        end
    endtask

    task automatic reset_and_check();
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(unit_en == 5'h0 && strobes() == 8'h0, "R1 quiet in reset",
            {unit_en, strobes()}, 0);
        chk(rom_addr == 8'h00, "R1 address in reset", rom_addr, 0);
        rst = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'd2024));
        for (int a = 0; a < 256; a++) rom[a] = 8'($urandom_range(0, 255));
        // Directed corner cases
        rom[8'h10] = 8'hB1; rom[8'h11] = 8'hA5;   // load, page 3
        rom[8'h12] = 8'h05; rom[8'h13] = 8'hFE;   // jump to 0xFE
        rom[8'hFE] = 8'h73; rom[8'hFF] = 8'h3C;   // ALU, then wrap to 0x00
        rom[8'h00] = 8'h06; rom[8'h01] = 8'h40;   // jz taken (flag forced 1)
        rom[8'h40] = 8'h06; rom[8'h41] = 8'h90;   // jz not taken (flag forced 0)
        rom[8'h42] = 8'h2C; rom[8'h43] = 8'h11;   // unassigned class 12
        rom[8'h44] = 8'h02; rom[8'h45] = 8'h77;   // store
        rom[8'h46] = 8'h44; rom[8'h47] = 8'h00;   // shift
        rom[8'h48] = 8'h07; rom[8'h49] = 8'h01;   // output port
        rom[8'h4A] = 8'h08; rom[8'h4B] = 8'h02;   // input port
        rom[8'h4C] = 8'h00; rom[8'h4D] = 8'hFF;   // nop
        rom[8'h4E] = 8'h05; rom[8'h4F] = 8'h10;   // back to boot

        @(negedge clk);
        reset_and_check();
        run_prog(400);
        reset_and_check();
        run_prog(300);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule